// File: doc/BRIEF.md
# Lockable Tree Pseudo-LRU Replacement Controller

This block holds the replacement state of an 8-way set-associative cache, one tree of seven state bits per set. Every hit to a line and every fill of a new line marks that way as most recently used in its set, and at any time the block names the way to replace next in the set selected by a lookup index. The tag and data arrays sit outside; the block sees only the set index, the way number and the access strobes.

Two controls change replacement without touching the cache contents. A freeze mask holds chosen inner nodes of the tree at their present value, so updates cannot steer the victim search into the part of the set those nodes keep away; the leaf nodes can never be frozen, so at least two ways of every set stay available. A global lock withholds any victim. A one-cycle invert strobe complements the whole state array at once, which reverses the order in which ways come up for replacement.

Top module: `plru_lock_ctrl`

## Requirements
- R1: After reset every state bit of every set is 0, so each set reports way 0 as victim and `no_victim` is 0.
- R2: A cycle with `hit_stb` or `alloc_stb` high (either, or both, with the same effect) writes three bits of the set at `acc_idx`, given way w (binary 0..7) on `acc_way`: the root bit takes the inverse of w[2]; for w[2]=0 bit B1 takes the inverse of w[1] and leaf B(3+w[1]) takes the inverse of w[0]; for w[2]=1 bit B2 takes the inverse of w[1] and leaf B(5+w[1]) takes the inverse of w[0]. So way 0 writes B0=1,B1=1,B3=1 and way 7 writes B0=0,B2=0,B6=0.
- R3: Bits not named in R2 keep their value; other sets are untouched; a cycle with both strobes low changes no state whatever `acc_idx` and `acc_way` carry.
- R4: The victim of the set at `lookup_idx` is found by walking the tree: victim bit 2 equals B0; victim bit 1 equals B2 when B0=1 and B1 when B0=0; victim bit 0 equals the leaf bit of the chosen pair (B3, B4, B5 or B6 for pairs 0..3).
- R5: While `freeze_mask[k]` is 1 (k=0 for B0, 1 for B1, 2 for B2), accesses leave that bit unchanged; the leaf bits B3..B6 always update, so even with all three mask bits set two ways of each set remain reachable.
- R6: While `global_lock` is 1, `no_victim` is 1 and `victim_way` is 0; accesses still update the state, and the victim they produce appears once the lock drops.
- R7: A cycle with `invert_stb` high complements all seven bits of every set in one step; an access strobed in the same cycle is discarded.
- R8: An access or inversion at one rising edge is seen on `victim_way` from just after that edge; `victim_way` follows `lookup_idx` with no clock in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| hit_stb | input | 1 | A line in the addressed set was hit |
| alloc_stb | input | 1 | A line in the addressed set was filled |
| acc_idx | input | 4 | Set index of the access |
| acc_way | input | 3 | Way of the access |
| lookup_idx | input | 4 | Set whose victim is reported |
| freeze_mask | input | 3 | Per inner node: hold B0, B1, B2 |
| global_lock | input | 1 | Withhold every victim |
| invert_stb | input | 1 | Complement the whole state array |
| victim_way | output | 3 | Way to replace next in set `lookup_idx` |
| no_victim | output | 1 | No way may be replaced |

## Verification
State writes land on the rising edge that samples a strobe, and the victim is a pure function of the stored tree and the lookup index, so every result is due one edge after its stimulus and no later. The bench changes inputs only at falling edges, lets the strobe be taken at the next rising edge, then at the following falling edge sets `lookup_idx` and compares a short settle time later, well before the next rising edge. Checks of the lock flag need no edge at all and are made within the same half cycle.

// File: rtl/plru_pkg.sv
package plru_pkg;

   // Heap numbering of the tree: node n has children 2n+1 (dir 0) and 2n+2 (dir 1).
   function automatic int plru_child(input int node, input logic dir);
      return 2 * node + 1 + int'(dir);
   endfunction

   // Number of tree levels for a power-of-two way count.
   function automatic int plru_levels(input int ways);
      int lv;
      lv = 0;
      while ((1 << lv) < ways) lv++;
      return lv;
   endfunction

endpackage

// File: rtl/plru_next_state.sv
module plru_next_state
   import plru_pkg::*;
#(
   parameter int WAYS = 8,
   localparam int TREE_W = WAYS - 1,
   localparam int WAY_W = plru_levels(WAYS),
   localparam int FRZ_W = WAYS / 2 - 1
) (
   input  logic [TREE_W-1:0] cur,
   input  logic [WAY_W-1:0]  way,
   input  logic [FRZ_W-1:0]  frz,
   output logic [TREE_W-1:0] nxt
);

   logic [TREE_W-1:0] frz_full;
   assign frz_full = TREE_W'(frz);

   // Walk from the root along the accessed way, pointing each node away from it.
   always_comb begin
      int   node;
      logic dir;
      nxt  = cur;
      node = 0;
      for (int lv = 0; lv < WAY_W; lv++) begin
         dir = way[WAY_W-1-lv];
         if (!frz_full[node]) nxt[node] = ~dir;
         node = plru_child(node, dir);
      end
   end

endmodule

// File: rtl/plru_victim_walk.sv
module plru_victim_walk
   import plru_pkg::*;
#(
   parameter int WAYS = 8,
   localparam int TREE_W = WAYS - 1,
   localparam int WAY_W = plru_levels(WAYS)
) (
   input  logic [TREE_W-1:0] tree,
   output logic [WAY_W-1:0]  way
);

   // Follow each node's direction bit; the leaf reached is the victim.
   always_comb begin
      int   node;
      logic dir;
      way  = '0;
      node = 0;
      for (int lv = 0; lv < WAY_W; lv++) begin
         dir = tree[node];
         way[WAY_W-1-lv] = dir;
         node = plru_child(node, dir);
      end
   end

endmodule

// File: rtl/plru_set_bank.sv
module plru_set_bank #(
   parameter int SETS = 16,
   parameter int TREE_W = 7,
   localparam int IDX_W = $clog2(SETS)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [IDX_W-1:0]              wr_idx,
   input  logic [TREE_W-1:0]             wr_tree,
   input  logic                          flip_all,
   output logic [SETS-1:0][TREE_W-1:0]   trees
);

   for (genvar s = 0; s < SETS; s++) begin : g_set
      logic hit_me;
      assign hit_me = wr_en && (wr_idx == IDX_W'(s));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        trees[s] <= '0;
         else if (flip_all) trees[s] <= ~trees[s];
         else if (hit_me)   trees[s] <= wr_tree;
      end
   end

endmodule

// File: rtl/plru_lock_ctrl.sv
module plru_lock_ctrl
   import plru_pkg::*;
#(
   parameter int SETS = 16,
   parameter int WAYS = 8,
   localparam int IDX_W = $clog2(SETS),
   localparam int WAY_W = plru_levels(WAYS),
   localparam int TREE_W = WAYS - 1,
   localparam int FRZ_W = WAYS / 2 - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit_stb,
   input  logic             alloc_stb,
   input  logic [IDX_W-1:0] acc_idx,
   input  logic [WAY_W-1:0] acc_way,
   input  logic [IDX_W-1:0] lookup_idx,
   input  logic [FRZ_W-1:0] freeze_mask,
   input  logic             global_lock,
   input  logic             invert_stb,
   output logic [WAY_W-1:0] victim_way,
   output logic             no_victim
);

   if (WAYS < 4 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
      $error("plru_lock_ctrl: WAYS must be a power of two, at least 4");
   end
   if (SETS < 2) begin : g_bad_sets
      $error("plru_lock_ctrl: SETS must be at least 2");
   end

   logic [SETS-1:0][TREE_W-1:0] trees;
   logic [TREE_W-1:0]           acc_tree;
   logic [TREE_W-1:0]           upd_tree;
   logic [TREE_W-1:0]           look_tree;
   logic [WAY_W-1:0]            walk_way;
   logic                        touch;

   assign touch     = hit_stb | alloc_stb;
   assign acc_tree  = trees[acc_idx];
   assign look_tree = trees[lookup_idx];

   plru_next_state #(.WAYS(WAYS)) upd_i (
      .cur (acc_tree),
      .way (acc_way),
      .frz (freeze_mask),
      .nxt (upd_tree)
   );

   plru_set_bank #(.SETS(SETS), .TREE_W(TREE_W)) bank_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (touch),
      .wr_idx   (acc_idx),
      .wr_tree  (upd_tree),
      .flip_all (invert_stb),
      .trees    (trees)
   );

   plru_victim_walk #(.WAYS(WAYS)) walk_i (
      .tree (look_tree),
      .way  (walk_way)
   );

   assign victim_way = global_lock ? '0 : walk_way;
   assign no_victim  = global_lock;

endmodule

// File: rtl/plru_lock_ctrl_chk.sv
module plru_lock_ctrl_chk
   import plru_pkg::*;
#(
   parameter int SETS = 16,
   parameter int WAYS = 8,
   localparam int IDX_W = $clog2(SETS),
   localparam int WAY_W = plru_levels(WAYS),
   localparam int FRZ_W = WAYS / 2 - 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             hit_stb,
   input logic             alloc_stb,
   input logic [IDX_W-1:0] acc_idx,
   input logic [WAY_W-1:0] acc_way,
   input logic [IDX_W-1:0] lookup_idx,
   input logic [FRZ_W-1:0] freeze_mask,
   input logic             global_lock,
   input logic             invert_stb,
   input logic [WAY_W-1:0] victim_way,
   input logic             no_victim
);

   // An unfrozen access to the watched set sends the victim to the other half.
   assert_other_half_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_stb || alloc_stb) && !invert_stb && !global_lock &&
      freeze_mask == '0 && acc_idx == lookup_idx
      |=> (!$stable(lookup_idx) || global_lock ||
           victim_way[WAY_W-1] != $past(acc_way[WAY_W-1])));

   assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_stb && !alloc_stb && !invert_stb
      |=> (!$stable(lookup_idx) || !$stable(global_lock) || $stable(victim_way)));

   assert_root_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
      freeze_mask[0] && !invert_stb && !global_lock
      |=> (!$stable(lookup_idx) || global_lock ||
           victim_way[WAY_W-1] == $past(victim_way[WAY_W-1])));

   assert_lock_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      global_lock |-> (no_victim && victim_way == '0));

   assert_unlock_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !global_lock |-> !no_victim);

   assert_invert_half_R7: assert property (@(posedge clk) disable iff (!rst_n)
      invert_stb && !global_lock
      |=> (!$stable(lookup_idx) || global_lock ||
           victim_way[WAY_W-1] != $past(victim_way[WAY_W-1])));

endmodule

bind plru_lock_ctrl plru_lock_ctrl_chk #(.SETS(SETS), .WAYS(WAYS)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .hit_stb     (hit_stb),
   .alloc_stb   (alloc_stb),
   .acc_idx     (acc_idx),
   .acc_way     (acc_way),
   .lookup_idx  (lookup_idx),
   .freeze_mask (freeze_mask),
   .global_lock (global_lock),
   .invert_stb  (invert_stb),
   .victim_way  (victim_way),
   .no_victim   (no_victim)
);

// File: tb/plru_lock_ctrl_tb.sv
module plru_lock_ctrl_tb_top;

   localparam int SETS = 8;
   localparam int IW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          hit_stb = 1'b0;
   logic          alloc_stb = 1'b0;
   logic [IW-1:0] acc_idx = '0;
   logic [2:0]    acc_way = '0;
   logic [IW-1:0] lookup_idx = '0;
   logic [2:0]    freeze_mask = '0;
   logic          global_lock = 1'b0;
   logic          invert_stb = 1'b0;
   logic [2:0]    victim_way;
   logic          no_victim;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [6:0] m [SETS];

   always #10 clk = ~clk;

   plru_lock_ctrl #(.SETS(SETS), .WAYS(8)) dut_i (
      .clk(clk), .rst_n(rst_n), .hit_stb(hit_stb), .alloc_stb(alloc_stb),
      .acc_idx(acc_idx), .acc_way(acc_way), .lookup_idx(lookup_idx),
      .freeze_mask(freeze_mask), .global_lock(global_lock),
      .invert_stb(invert_stb), .victim_way(victim_way), .no_victim(no_victim)
   );

   function automatic logic [6:0] mupd(input logic [6:0] s, input logic [2:0] w,
                                       input logic [2:0] fm);
      logic [6:0] r;
      r = s;
      if (!fm[0]) r[0] = ~w[2];
      if (!w[2]) begin
         if (!fm[1]) r[1] = ~w[1];
         r[3 + w[1]] = ~w[0];
      end else begin
         if (!fm[2]) r[2] = ~w[1];
         r[5 + w[1]] = ~w[0];
      end
      return r;
   endfunction

   function automatic logic [2:0] mvic(input logic [6:0] s);
      logic hi, mid, leaf;
      hi   = s[0];
      mid  = hi ? s[2] : s[1];
      leaf = s[3 + 2 * hi + mid];
      return {hi, mid, leaf};
   endfunction

   task automatic look(input int idx, input string tag);
      logic [2:0] ew;
      logic en;
      lookup_idx = IW'(idx);
      #2;
      ew = global_lock ? 3'd0 : mvic(m[idx]);
      en = global_lock;
      n_vec++;
      if (victim_way !== ew || no_victim !== en) begin
         n_bad++;
         $display("FAIL %s set %0d: victim=%0d no_victim=%0b, expected %0d/%0b",
                  tag, idx, victim_way, no_victim, ew, en);
      end
   endtask

   task automatic access(input int idx, input int way, input bit h, input bit a,
                         input string tag);
      @(negedge clk);
      acc_idx = IW'(idx); acc_way = 3'(way); hit_stb = h; alloc_stb = a;
      @(negedge clk);
      hit_stb = 1'b0; alloc_stb = 1'b0;
      if (h || a) m[idx] = mupd(m[idx], 3'(way), freeze_mask);
      look(idx, tag);
   endtask

   task automatic sweep(input string tag);
      for (int s = 0; s < SETS; s++) look(s, tag);
   endtask

   initial begin
      for (int s = 0; s < SETS; s++) m[s] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      sweep("R1 reset");

      // R2/R4: every way in every set, hit and alloc strobes alternating
      for (int s = 0; s < SETS; s++)
         for (int k = 0; k < 8; k++)
            access(s, (k * 5 + s) & 7, k[0], !k[0] || k == 4, "R2 R4 update/walk");
      sweep("R3 other sets intact");

      // R3: strobes low, address lines busy
      for (int k = 0; k < 8; k++) access(k, 7 - k, 1'b0, 1'b0, "R3 no strobe");

      // R5: every freeze pattern, all ways on one set
      for (int fm = 1; fm < 8; fm++) begin
         @(negedge clk);
         freeze_mask = 3'(fm);
         for (int w = 0; w < 8; w++) access(fm, (w * 3 + fm) & 7, 1'b1, 1'b0, "R5 frozen");
      end
      @(negedge clk);
      freeze_mask = 3'b111;
      for (int w = 0; w < 8; w++) access(0, w, 1'b0, 1'b1, "R5 two ways open");
      freeze_mask = '0;

      // R7: whole-array inversion, then inversion racing an access
      @(negedge clk);
      invert_stb = 1'b1;
      @(negedge clk);
      invert_stb = 1'b0;
      for (int s = 0; s < SETS; s++) m[s] = ~m[s];
      sweep("R7 invert all");
      @(negedge clk);
      invert_stb = 1'b1; hit_stb = 1'b1; acc_idx = 3'd2; acc_way = 3'd5;
      @(negedge clk);
      invert_stb = 1'b0; hit_stb = 1'b0;
      for (int s = 0; s < SETS; s++) m[s] = ~m[s];
      sweep("R7 access dropped");

      // R6: lock hides the victim, state keeps tracking, R8 release is immediate
      @(negedge clk);
      global_lock = 1'b1;
      sweep("R6 locked");
      access(4, 3, 1'b1, 1'b0, "R6 locked access");
      access(4, 6, 1'b0, 1'b1, "R6 locked alloc");
      global_lock = 1'b0;
      look(4, "R6 R8 after unlock");
      sweep("R6 unlocked sets");

      // R8: lookup index changes with no clock in between
      for (int s = SETS - 1; s >= 0; s--) look(s, "R8 lookup comb");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run still busy, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule